// File: doc/BRIEF.md
# Low-Power-Aware GPIO Port Controller

This block is an eight-pin general-purpose I/O port with a small register file. Software sets the output data, the direction of each pin, the pull-up enables and the external-interrupt enables through a single-cycle write strobe and a two-bit address. Register reads are combinational. For each pin the block drives the pad's output enable, output value, pull-up enable and input-gate enable. It returns a synchronised pin value and a per-pin interrupt input for the interrupt controller.

A power-mode input and a safe-state bit decide how the pads behave while the chip is powered down. In run mode and in sleep mode, and also in the deep modes (stop and time-base timer) when the safe-state bit is clear, every pin is an ordinary I/O pin. In a deep mode with the safe-state bit set, every output driver is switched off whatever the direction register holds. A pin with its pull-up enabled is held high. A pin without a pull-up floats, and its input is gated off unless it is one of the lower seven pins and is enabled as an interrupt input, which keeps the wake-up path alive.

Top module: `lp_gpio_port`

## Requirements
- R1: While reset is held and in the cycle after it is released, pad_oe and pad_pu are all 0. After reset the direction, pull-up and interrupt-enable registers read 0.
- R2: Reset does not change the output data register. A value written before reset reads back unchanged after it.
- R3: Address 0 selects output data, address 1 direction (1 = output), address 2 pull-up enable (1 = on) and address 3 interrupt enable. Address 3 has bits 6:0 for pins 0 to 6. Its bit 7 always reads 0 and a write to it is ignored.
- R4: Outside the forced safe state, pad_oe equals the direction register, pad_out equals the data register and pad_ie is all ones.
- R5: Outside the forced safe state, pad_pu is the pull-up register with every output pin masked off (pu & ~dir).
- R6: A deep mode (pwr_mode 2 = stop or 3 = time-base timer) with pin_safe at 0 produces the same pad controls as run mode (0) or sleep mode (1).
- R7: In the forced safe state (deep mode and pin_safe = 1), pad_oe is 0 on every pin, whatever the direction register holds.
- R8: In the forced safe state, pad_pu equals the pull-up register, and every pin with its pull-up on has pad_ie = 0.
- R9: In the forced safe state, a pin without a pull-up has pad_ie equal to its interrupt-enable bit for pins 0 to 6. Pin 7 always has pad_ie = 0.
- R10: pin_val is pad_in AND pad_ie, delayed by a two-flop synchroniser. A gated-off pin reads 0, and a pad change shows in the second cycle after it.
- R11: irq_in[i] is pin_val[i] AND interrupt-enable bit i, for pins 0 to 6.
- R12: The pad controls are registered. They take their new value one clock after the register write or power-mode change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| pwr_mode | input | 2 | 0 run, 1 sleep, 2 stop, 3 time-base timer |
| pin_safe | input | 1 | Force pins to safe state in deep modes |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad output-driver enable |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad pull-up enable |
| pad_ie | output | 8 | Pad input-gate enable |
| pin_val | output | 8 | Synchronised, gated pin levels |
| irq_in | output | 7 | Interrupt-enabled pin levels, pins 0 to 6 |

## Verification
The assertions check the following on every cycle against the previous cycle's mode inputs. Drivers are off in the forced state, and no pin there has both its pull-up and its input gate on. Pin 7's gate is shut in that state. Pull-ups never coexist with drivers in the ordinary state, and input gates are all open there. They also check that the pad controls are clear just after reset and that an interrupt input never rises without its pin value. The bench's scenarios alone can show the rest. Those are the register map and the survival of the data register across reset, the exact pull-up and gate values for every combination of direction, pull-up and interrupt enable on every pin in all eight mode settings, and the one-cycle and two-cycle latencies.

// File: rtl/lp_gpio_pkg.sv
package lp_gpio_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_STOP  = 2'd2,
    PM_TBT   = 2'd3
  } pwr_mode_e;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_DIR  = 2'd1;
  localparam logic [1:0] REG_PU   = 2'd2;
  localparam logic [1:0] REG_IRQ  = 2'd3;

  function automatic logic is_deep(input pwr_mode_e m);
    return (m == PM_STOP) || (m == PM_TBT);
  endfunction
endpackage

// File: rtl/lp_gpio_regs.sv
module lp_gpio_regs
  import lp_gpio_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int IRQ_PINS = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [WIDTH-1:0]    wr_data,
  output logic [WIDTH-1:0]    rd_data,
  output logic [WIDTH-1:0]    data_q,
  output logic [WIDTH-1:0]    dir_q,
  output logic [WIDTH-1:0]    pu_q,
  output logic [IRQ_PINS-1:0] irq_q
);
  localparam int PAD_W = WIDTH - IRQ_PINS;

  // output data: deliberately not reset
  always_ff @(posedge clk) begin
    if (wr_en && addr == REG_DATA) data_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      pu_q  <= '0;
      irq_q <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_DIR: dir_q <= wr_data;
        REG_PU:  pu_q  <= wr_data;
        REG_IRQ: irq_q <= wr_data[IRQ_PINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      REG_DATA: rd_data = data_q;
      REG_DIR:  rd_data = dir_q;
      REG_PU:   rd_data = pu_q;
      default:  rd_data = {{PAD_W{1'b0}}, irq_q};
    endcase
  end
endmodule

// File: rtl/lp_gpio_pinctl.sv
module lp_gpio_pinctl #(
  parameter int WIDTH    = 8,
  parameter int IRQ_PINS = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                force_safe,
  input  logic [WIDTH-1:0]    data_q,
  input  logic [WIDTH-1:0]    dir_q,
  input  logic [WIDTH-1:0]    pu_q,
  input  logic [IRQ_PINS-1:0] irq_q,
  output logic [WIDTH-1:0]    pad_oe,
  output logic [WIDTH-1:0]    pad_out,
  output logic [WIDTH-1:0]    pad_pu,
  output logic [WIDTH-1:0]    pad_ie
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic wake_ok;
    if (i < IRQ_PINS) begin : g_irq
      assign wake_ok = irq_q[i];
    end else begin : g_noirq
      assign wake_ok = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= 1'b0;
        pad_pu[i]  <= 1'b0;
        pad_ie[i]  <= 1'b1;
      end else if (force_safe) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= data_q[i];
        pad_pu[i]  <= pu_q[i];
        pad_ie[i]  <= ~pu_q[i] & wake_ok;
      end else begin
        pad_oe[i]  <= dir_q[i];
        pad_out[i] <= data_q[i];
        pad_pu[i]  <= pu_q[i] & ~dir_q[i];
        pad_ie[i]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lp_gpio_sync.sv
module lp_gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lp_gpio_port.sv
module lp_gpio_port
  import lp_gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int IRQ_PINS    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [WIDTH-1:0]    wr_data,
  output logic [WIDTH-1:0]    rd_data,
  input  logic [1:0]          pwr_mode,
  input  logic                pin_safe,
  input  logic [WIDTH-1:0]    pad_in,
  output logic [WIDTH-1:0]    pad_oe,
  output logic [WIDTH-1:0]    pad_out,
  output logic [WIDTH-1:0]    pad_pu,
  output logic [WIDTH-1:0]    pad_ie,
  output logic [WIDTH-1:0]    pin_val,
  output logic [IRQ_PINS-1:0] irq_in
);
  logic [WIDTH-1:0]    data_q, dir_q, pu_q;
  logic [IRQ_PINS-1:0] irq_q;
  logic                force_safe;
  logic [WIDTH-1:0]    gated_in;

  assign force_safe = pin_safe & is_deep(pwr_mode_e'(pwr_mode));

  lp_gpio_regs #(.WIDTH(WIDTH), .IRQ_PINS(IRQ_PINS)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .data_q(data_q), .dir_q(dir_q), .pu_q(pu_q),
    .irq_q(irq_q)
  );

  lp_gpio_pinctl #(.WIDTH(WIDTH), .IRQ_PINS(IRQ_PINS)) i_pinctl (
    .clk(clk), .rst(rst), .force_safe(force_safe), .data_q(data_q),
    .dir_q(dir_q), .pu_q(pu_q), .irq_q(irq_q), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu), .pad_ie(pad_ie)
  );

  assign gated_in = pad_in & pad_ie;

  lp_gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(gated_in), .q(pin_val)
  );

  assign irq_in = pin_val[IRQ_PINS-1:0] & irq_q;
endmodule

// File: rtl/lp_gpio_port_chk.sv
module lp_gpio_port_chk #(
  parameter int WIDTH    = 8,
  parameter int IRQ_PINS = 7
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          pwr_mode,
  input logic                pin_safe,
  input logic [WIDTH-1:0]    pad_oe,
  input logic [WIDTH-1:0]    pad_pu,
  input logic [WIDTH-1:0]    pad_ie,
  input logic [WIDTH-1:0]    pin_val,
  input logic [IRQ_PINS-1:0] irq_in
);
  logic armed, forced_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      forced_d <= 1'b0;
    end else begin
      armed    <= 1'b1;
      forced_d <= pin_safe & pwr_mode[1];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_pu == '0));

  // R7
  forced_drv_off_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && forced_d) |-> pad_oe == '0);

  // R8
  forced_pu_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && forced_d) |-> (pad_pu & pad_ie) == '0);

  // R9
  forced_top_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && forced_d) |-> !pad_ie[WIDTH-1]);

  // R5
  run_pu_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !forced_d) |-> (pad_pu & pad_oe) == '0);

  // R4
  run_gate_open_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !forced_d) |-> pad_ie == '1);

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_in & ~pin_val[IRQ_PINS-1:0]) == '0);
endmodule

bind lp_gpio_port lp_gpio_port_chk #(.WIDTH(WIDTH), .IRQ_PINS(IRQ_PINS)) i_chk (
  .clk(clk), .rst(rst), .pwr_mode(pwr_mode), .pin_safe(pin_safe),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_ie(pad_ie), .pin_val(pin_val),
  .irq_in(irq_in)
);

// File: tb/test_lp_gpio_port.sv
module test_lp_gpio_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic [1:0] pwr_mode = 2'd0;
  logic       pin_safe = 1'b0;
  logic [7:0] pad_in = 8'd0;
  logic [7:0] pad_oe, pad_out, pad_pu, pad_ie, pin_val;
  logic [6:0] irq_in;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_data, m_dir, m_pu;
  logic [6:0] m_irq;

  always #4 clk = ~clk;

  lp_gpio_port i_lp_gpio_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pwr_mode(pwr_mode), .pin_safe(pin_safe),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .pad_ie(pad_ie), .pin_val(pin_val), .irq_in(irq_in)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check_pads(input string tag);
    logic       forced;
    logic [7:0] e_oe, e_pu, e_ie;
    forced = pin_safe && pwr_mode[1];
    if (!forced) begin
      e_oe = m_dir; e_pu = m_pu & ~m_dir; e_ie = 8'hFF;
    end else begin
      e_oe = 8'h00; e_pu = m_pu; e_ie = ~m_pu & {1'b0, m_irq};
    end
    check({tag, " R4/R6/R7 oe"}, pad_oe, e_oe);
    check({tag, " R4 out"}, pad_out, m_data);
    check({tag, " R5/R8 pu"}, pad_pu, e_pu);
    check({tag, " R4/R8/R9 ie"}, pad_ie, e_ie);
    check({tag, " R10 pin_val"}, pin_val, pad_in & e_ie);
    check({tag, " R11 irq"}, {1'b0, irq_in}, {1'b0, pad_in[6:0] & e_ie[6:0] & m_irq});
  endtask

  initial begin
    logic [7:0] v;
    settle(3);
    // R1: pad controls held clear during reset
    check("R1 oe in reset", pad_oe, 8'h00);
    check("R1 pu in reset", pad_pu, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe after reset", pad_oe, 8'h00);
    check("R1 pu after reset", pad_pu, 8'h00);
    rd(2'd1, v); check("R1 dir reg", v, 8'h00);
    rd(2'd2, v); check("R1 pu reg", v, 8'h00);
    rd(2'd3, v); check("R1 irq reg", v, 8'h00);

    // R2: data survives reset
    wr(2'd0, 8'h3C);
    @(negedge clk); rst = 1'b1; settle(3); rst = 1'b0;
    rd(2'd0, v); check("R2 data kept", v, 8'h3C);

    // R3: register map, interrupt bit 7 absent
    wr(2'd1, 8'h5A); rd(2'd1, v); check("R3 dir map", v, 8'h5A);
    wr(2'd2, 8'hC3); rd(2'd2, v); check("R3 pu map", v, 8'hC3);
    wr(2'd3, 8'hFF); rd(2'd3, v); check("R3 irq bit7", v, 8'h7F);
    wr(2'd0, 8'h96); rd(2'd0, v); check("R3 data map", v, 8'h96);

    // R12: one-clock latency of pad controls after write
    wr(2'd1, 8'h00); settle(2);
    wr(2'd1, 8'hF0);
    check("R12 oe old", pad_oe, 8'h00);
    @(negedge clk);
    check("R12 oe new", pad_oe, 8'hF0);
    // R12: one-clock latency after mode change
    pin_safe = 1'b1; pwr_mode = 2'd2;
    @(negedge clk);
    check("R12 forced oe", pad_oe, 8'h00);
    pwr_mode = 2'd0; settle(2);

    // R10: two-cycle synchroniser latency
    pad_in = 8'h00; settle(3);
    pad_in = 8'hA5;
    @(negedge clk); check("R10 sync stage1", pin_val, 8'h00);
    @(negedge clk); check("R10 sync stage2", pin_val, 8'hA5);

    // sweep: every pin sees every dir/pu/irq combination in all modes
    for (int rot = 0; rot < 8; rot++) begin
      m_dir = 8'h00; m_pu = 8'h00; m_irq = 7'h00;
      for (int p = 0; p < 8; p++) begin
        int c;
        c = (p + rot) % 8;
        m_dir[p] = c[0];
        m_pu[p]  = c[1];
        if (p < 7) m_irq[p] = c[2];
      end
      m_data = 8'h5A ^ 8'(rot * 37);
      wr(2'd0, m_data); wr(2'd1, m_dir); wr(2'd2, m_pu); wr(2'd3, {1'b0, m_irq});
      for (int md = 0; md < 8; md++) begin
        pwr_mode = md[1:0];
        pin_safe = md[2];
        for (int pat = 0; pat < 2; pat++) begin
          pad_in = pat == 0 ? 8'hFF : 8'(8'hC5 ^ rot);
          settle(4);
          check_pads($sformatf("rot%0d mode%0d safe%0d", rot, md[1:0], md[2]));
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule